// File: doc/BRIEF.md
# Carrier Detect Qualifier with Dropout Hold

This block decides whether a voiceband FSK carrier is present. Its input is a per-sample flag, raised by an upstream level comparator whenever the band-limited signal carries enough energy. The block does not trust that flag directly. Time is cut into one-millisecond windows by a prescaler on the 3.5795 MHz system clock. Each window that saw any energy raises a qualification count, and each silent window lowers it. The carrier is declared present when the count reaches its threshold.

Once declared, the indication does not follow the raw flag. It stays asserted through short gaps. It drops only after a fixed run of consecutive clock samples with no energy, a run equal to ten milliseconds, and every active sample restarts that run. The block drives an active-low carrier-detect pin, together with an output enable that gives either push-pull or open-drain behaviour. It also gives an active-high carrier-valid level that gates the downstream bit-timing recovery. A power-down input clears all state and holds the pin inactive.

Top module: `carrier_qual`

## Requirements
- R1: A millisecond window lasts TICK_DIV clock cycles. The first window after reset or after power-down is released spans the first TICK_DIV rising edges. One active energy sample anywhere in a window, including its first or its last cycle, marks the whole window active.
- R2: Detection is declared on the rising edge that closes the window in which the qualification count reaches QUAL_MIN. At that edge cd_n_o goes low and carrier_ok_o goes high, and at no other point in the window.
- R3: While no carrier is detected, an active window adds one to the qualification count. A silent window subtracts one, so the count is not cleared. At zero it stays at zero and does not wrap.
- R4: While detected, every active energy sample restarts the quiet timer, so a gap of any length shorter than the hold period leaves the detection unchanged.
- R5: Detection is released on the rising edge that samples the HOLD_MS*TICK_DIV-th consecutive inactive energy sample after the last active one. After a release, detection needs QUAL_MIN fresh active windows again.
- R6: While pwr_down_i is high, the detection state, the qualification count, the quiet timer and the prescaler are cleared. Energy is ignored, and from one clock after pwr_down_i is sampled high, cd_n_o is 1 and carrier_ok_o is 0. After release, detection again needs QUAL_MIN active windows counted from a fresh prescaler phase.
- R7: With push_pull_i = 1, cd_oe_o is always 1. With push_pull_i = 0 (open-drain), cd_oe_o is 1 only while cd_n_o is 0, and the pin floats otherwise. This includes power-down, where the push-pull pin drives high and the open-drain pin floats.
- R8: After synchronous reset, cd_n_o is 1, carrier_ok_o is 0 and, in open-drain mode, cd_oe_o is 0.
- R9: carrier_ok_o is always the complement of cd_n_o. It is the enable that lets downstream data recovery use the demodulator output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (3.5795 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| pwr_down_i | input | 1 | Power-down request, active high |
| push_pull_i | input | 1 | 1: push-pull pin, 0: open-drain pin |
| energy_i | input | 1 | Per-sample in-band energy flag from the level comparator |
| cd_n_o | output | 1 | Carrier detect, active low |
| cd_oe_o | output | 1 | Output enable for the carrier-detect pad |
| carrier_ok_o | output | 1 | Carrier valid enable for data-timing recovery |

## Verification
A wrong qualification count shows up at cd_n_o as detection arriving one or more whole windows too early or too late. The bench checks the edge before and the edge of the expected change, so an off-by-one in the up/down count, a count that resets on a silent window, or a count that underflows is visible within one window. A quiet timer that fails to restart, or that ends one sample early or late, moves the release edge, and the sweep checks both sides of that edge. Power-down leftovers show up as detection one window early after wake-up, and the position sweep of single active samples exposes a prescaler phase error.

// File: rtl/carrier_qual_pkg.sv
package carrier_qual_pkg;

  typedef enum logic {
    PAD_OPEN_DRAIN = 1'b0,
    PAD_PUSH_PULL  = 1'b1
  } pad_drive_e;

  // Bits needed to hold values 0..n
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/ms_tick_gen.sv
module ms_tick_gen #(
  parameter int unsigned TICK_DIV = 3580
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  output logic tick_o
);
  import carrier_qual_pkg::*;

  localparam int unsigned W = cnt_bits(TICK_DIV - 1);
  localparam logic [W-1:0] LAST = W'(TICK_DIV - 1);

  logic [W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)          phase_q <= '0;
    else if (phase_q == LAST)  phase_q <= '0;
    else                       phase_q <= phase_q + 1'b1;
  end

  assign tick_o = (phase_q == LAST);

  generate
    if (TICK_DIV > 1) begin : g_spacing
      // R1: window closings are never back to back
      a_r1_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick_o && !clr_i) |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/win_qualifier.sv
module win_qualifier #(
  parameter int unsigned QUAL_MIN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic tick_i,
  input  logic energy_i,
  output logic hit_o
);
  import carrier_qual_pkg::*;

  localparam int unsigned W = cnt_bits(QUAL_MIN);
  localparam logic [W-1:0] PRE_HIT = W'(QUAL_MIN - 1);

  logic         seen_q;
  logic [W-1:0] score_q;
  logic         win_act;

  assign win_act = seen_q | energy_i;

  always_ff @(posedge clk) begin
    if (rst || clr_i)  seen_q <= 1'b0;
    else if (tick_i)   seen_q <= 1'b0;
    else               seen_q <= win_act;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      score_q <= '0;
    end else if (tick_i) begin
      if (win_act)              score_q <= score_q + 1'b1;
      else if (score_q != '0)   score_q <= score_q - 1'b1;
    end
  end

  assign hit_o = tick_i && win_act && (score_q == PRE_HIT);

  // R3: the score moves by at most one per clock
  a_r3_step_one: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> (score_q == $past(score_q)) ||
               (score_q == $past(score_q) + 1'b1) ||
               (score_q + 1'b1 == $past(score_q)));

  // R3: an idle window at zero leaves the score at zero
  a_r3_floor: assert property (@(posedge clk) disable iff (rst)
    (score_q == '0 && tick_i && !win_act) |=> (score_q == '0));

endmodule

// File: rtl/quiet_timer.sv
module quiet_timer #(
  parameter int unsigned LIMIT = 35800
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic run_i,
  input  logic energy_i,
  output logic expire_o
);
  import carrier_qual_pkg::*;

  localparam int unsigned W = cnt_bits(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i || !run_i)  gap_q <= '0;
    else if (energy_i)           gap_q <= '0;
    else                         gap_q <= gap_q + 1'b1;
  end

  assign expire_o = run_i && !energy_i && (gap_q == LAST);

  // R5: the gap counter never passes the hold length
  a_r5_gap_bound: assert property (@(posedge clk) disable iff (rst)
    run_i |-> (gap_q <= LAST));

endmodule

// File: rtl/carrier_qual.sv
module carrier_qual #(
  parameter int unsigned TICK_DIV = 3580,
  parameter int unsigned QUAL_MIN = 8,
  parameter int unsigned HOLD_MS  = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_down_i,
  input  logic push_pull_i,
  input  logic energy_i,
  output logic cd_n_o,
  output logic cd_oe_o,
  output logic carrier_ok_o
);
  import carrier_qual_pkg::*;

  localparam int unsigned HOLD_CYC = HOLD_MS * TICK_DIV;

  logic       tick;
  logic       hit;
  logic       expire;
  logic       det_q;
  pad_drive_e drive_mode;

  assign drive_mode = pad_drive_e'(push_pull_i);

  ms_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (pwr_down_i),
    .tick_o (tick)
  );

  win_qualifier #(.QUAL_MIN(QUAL_MIN)) u_qual (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (pwr_down_i | det_q),
    .tick_i   (tick),
    .energy_i (energy_i),
    .hit_o    (hit)
  );

  quiet_timer #(.LIMIT(HOLD_CYC)) u_quiet (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (pwr_down_i),
    .run_i    (det_q),
    .energy_i (energy_i),
    .expire_o (expire)
  );

  always_ff @(posedge clk) begin
    if (rst || pwr_down_i)    det_q <= 1'b0;
    else if (!det_q && hit)   det_q <= 1'b1;
    else if (det_q && expire) det_q <= 1'b0;
  end

  assign cd_n_o       = ~det_q;
  assign carrier_ok_o = det_q;
  assign cd_oe_o      = (drive_mode == PAD_PUSH_PULL) ? 1'b1 : det_q;

  // R2: detection only begins at a window-closing edge
  a_r2_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(det_q) |-> $past(tick));

  // R6: power-down forces the indication inactive one clock later
  a_r6_pwrdn_clears: assert property (@(posedge clk) disable iff (rst)
    pwr_down_i |=> !det_q);

  // R4: an active sample while detected keeps detection
  a_r4_active_holds: assert property (@(posedge clk) disable iff (rst)
    (det_q && energy_i && !pwr_down_i) |=> det_q);

endmodule

// File: tb/carrier_qual_tb.sv
module carrier_qual_tb;

  localparam int DIV  = 4;
  localparam int QMIN = 8;
  localparam int HMS  = 3;
  localparam int HOLD = HMS * DIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_down = 1'b0;
  logic push_pull = 1'b0;
  logic energy = 1'b0;
  logic cd_n, cd_oe, c_ok;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  carrier_qual #(.TICK_DIV(DIV), .QUAL_MIN(QMIN), .HOLD_MS(HMS)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .pwr_down_i   (pwr_down),
    .push_pull_i  (push_pull),
    .energy_i     (energy),
    .cd_n_o       (cd_n),
    .cd_oe_o      (cd_oe),
    .carrier_ok_o (c_ok)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // detected state at the pins, including R9 complement
  task automatic chk_det(input string req, input logic exp);
    chk(req, c_ok, exp);
    chk({req, " R9"}, cd_n, ~exp);
  endtask

  // one clock: drive at negedge, sample at next negedge
  task automatic edge1(input logic en);
    energy = en;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) edge1(1'b0);
  endtask

  // pos < 0: active whole window; otherwise one active sample at pos
  task automatic window(input logic act, input int pos);
    for (int i = 0; i < DIV; i++) edge1(act && (pos < 0 || i == pos));
  endtask

  task automatic windows(input logic act, input int n);
    for (int i = 0; i < n; i++) window(act, -1);
  endtask

  task automatic resync();
    pwr_down = 1'b1;
    edge1(1'b0);
    edge1(1'b0);
    pwr_down = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    edge1(1'b0);
    edge1(1'b0);
    rst = 1'b0;

    // R8 reset state
    chk_det("R8 reset", 1'b0);
    chk("R8 open-drain oe at reset", cd_oe, 1'b0);

    // R2 qualification: seven windows not enough, eighth closes on its last edge
    windows(1'b1, QMIN - 1);
    chk_det("R2 seven windows", 1'b0);
    for (int i = 0; i < DIV - 1; i++) edge1(1'b1);
    chk_det("R2 before closing edge", 1'b0);
    edge1(1'b1);
    chk_det("R2 at closing edge", 1'b1);
    chk("R7 open-drain oe when low", cd_oe, 1'b1);

    // R5 exact release after HOLD inactive samples
    quiet(HOLD - 1);
    chk_det("R5 one sample before release", 1'b1);
    quiet(1);
    chk_det("R5 release edge", 1'b0);
    chk("R7 open-drain floats after release", cd_oe, 1'b0);

    // R4 restart on a single active sample during hold
    resync();
    windows(1'b1, QMIN);
    chk_det("R4 detect", 1'b1);
    quiet(HOLD - 1);
    edge1(1'b1);
    quiet(HOLD - 1);
    chk_det("R4 hold restarted", 1'b1);
    quiet(1);
    chk_det("R4 release after restart", 1'b0);
    // R5 requalification after release: a few active windows do not re-detect
    windows(1'b1, 3);
    chk_det("R5 requalify needed", 1'b0);

    // R3 silent window decrements instead of clearing
    resync();
    windows(1'b1, QMIN - 1);
    windows(1'b0, 1);
    windows(1'b1, 1);
    chk_det("R3 after dip count below threshold", 1'b0);
    windows(1'b1, 1);
    chk_det("R3 reached after dip", 1'b1);

    // R3 floor at zero
    resync();
    windows(1'b0, 3);
    windows(1'b1, QMIN - 1);
    chk_det("R3 floor not early", 1'b0);
    windows(1'b1, 1);
    chk_det("R3 floor no underflow", 1'b1);

    // R1 sweep of the single active sample position
    for (int p = 0; p < DIV; p++) begin
      resync();
      for (int w = 0; w < QMIN - 1; w++) window(1'b1, p);
      chk_det($sformatf("R1 pos %0d seven windows", p), 1'b0);
      window(1'b1, p);
      chk_det($sformatf("R1 pos %0d detect", p), 1'b1);
    end

    // R6 power-down while detected, energy ignored, fresh restart
    pwr_down = 1'b1;
    edge1(1'b1);
    chk_det("R6 forced one clock after", 1'b0);
    chk("R6 open-drain floats", cd_oe, 1'b0);
    for (int i = 0; i < (QMIN + 2) * DIV; i++) edge1(1'b1);
    chk_det("R6 energy ignored", 1'b0);
    pwr_down = 1'b0;
    windows(1'b1, QMIN - 1);
    chk_det("R6 counters cleared", 1'b0);
    windows(1'b1, 1);
    chk_det("R6 detect after wake", 1'b1);

    // R7 push-pull pad
    push_pull = 1'b1;
    edge1(1'b1);
    chk("R7 push-pull oe when low", cd_oe, 1'b1);
    pwr_down = 1'b1;
    edge1(1'b1);
    chk("R7 push-pull oe in power-down", cd_oe, 1'b1);
    chk("R7 push-pull high in power-down", cd_n, 1'b1);
    pwr_down = 1'b0;
    edge1(1'b0);
    chk("R7 push-pull oe idle", cd_oe, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule